// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Flags

This block holds a small set of one-bit ownership flags that two independent agents, a left port and a right port, use to claim and hand back shared resources. Each port has its own strobes, a flag index and a data bus. A port reaches the flag space only while its flag strobe is low and its memory enable is high. Each port strobe set is sampled on one common clock.

A port claims a flag by writing 0 and gives it back by writing 1. Only data bit 0 of a write matters. A read places the flag as that port sees it on every bit of the read bus. The owner reads 0. The other port reads 1 for as long as the owner holds the flag. A claim on a flag that is already held is not lost. It is remembered, and it is granted on its own once the owner gives the flag back. When both ports claim the same free flag in the same cycle, the left port always wins.

Driving the flag strobe low while the memory enable is also low is a wiring error. The block performs no access in that case and raises a per-port misuse output.

Top module: `xsema_dual`

## Requirements
- R1: After reset every flag is free, so a read of any index from either port returns all ones with the read-enable high.
- R2: A port accesses the flags only when `sem_n`=0 and `ce_n`=1. Under any other strobe combination its writes change no flag, and its `rdata_oe` is 0 with `rdata` all zeros.
- R3: With `ce_n`=0 and `sem_n`=0 on a port, `bad_sel` is 1 for that port. That cycle neither reads nor writes any flag.
- R4: A write (`rw`=0) uses only `wdata[0]`: 0 claims the flag and 1 gives it back. Bits 1 and up are ignored.
- R5: A read (`rw`=1, `oe_n`=0) drives the port's view of the addressed flag on every `rdata` bit and sets `rdata_oe`. With `oe_n`=1, `rdata_oe` is 0 and `rdata` is all zeros.
- R6: A claim on a free flag is granted at the next clock edge. From then on the owner reads 0 and the other port reads 1.
- R7: A claim on a flag held by the other port is not granted. The claimer keeps reading 1, and the claim stays pending.
- R8: When both ports claim the same free flag in one cycle, the left port gets it and the right claim becomes pending.
- R9: When the owner gives back a flag that has a pending claim, the flag reads free for one cycle. At the clock edge after that, it belongs to the pending port.
- R10: Writing 1 releases a flag the port owns. The same write withdraws that port's pending claim, and it never frees a flag held by the other port.
- R11: The flags are independent: an access to index a, where a is taken from `addr[2:0]`, affects flag a only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst_n | input | 1 | Active-low reset, frees all flags |
| l_ce_n | input | 1 | Left memory enable, active low |
| l_sem_n | input | 1 | Left flag-space strobe, active low |
| l_rw | input | 1 | Left direction, 1 read, 0 write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | 3 | Left flag index |
| l_wdata | input | 9 | Left write data, bit 0 used |
| l_rdata | output | 9 | Left read data, flag replicated |
| l_rdata_oe | output | 1 | Left read bus driven |
| l_bad_sel | output | 1 | Left forbidden strobe combination |
| r_ce_n | input | 1 | Right memory enable, active low |
| r_sem_n | input | 1 | Right flag-space strobe, active low |
| r_rw | input | 1 | Right direction, 1 read, 0 write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | 3 | Right flag index |
| r_wdata | input | 9 | Right write data, bit 0 used |
| r_rdata | output | 9 | Right read data, flag replicated |
| r_rdata_oe | output | 1 | Right read bus driven |
| r_bad_sel | output | 1 | Right forbidden strobe combination |

## Verification
A wrong owner or pending bit shows up at the next read of that index: one port reads 0 while the other port should own the flag, or both ports read 1 for a cycle too many after a release. Because reads are combinational on the registered state, a fault in the claim logic is visible one clock after the write that caused it. A fault in the hand-over of a pending claim is visible two clocks after the release. The bench reads both ports right after every write sequence, so a lost pending claim, a tie resolved the wrong way, or a decode that lets a forbidden or memory cycle touch a flag shows up at once as a mismatched read word.

// File: rtl/xsema_pkg.sv
package xsema_pkg;

   // Who currently holds one flag
   typedef enum logic [1:0] {
      OWN_FREE  = 2'd0,
      OWN_LEFT  = 2'd1,
      OWN_RIGHT = 2'd2
   } own_e;

endpackage

// File: rtl/xsema_port_dec.sv
module xsema_port_dec #(
   parameter int DATA_W = 9
) (
   input  logic              ce_n,
   input  logic              sem_n,
   input  logic              rw,
   input  logic              oe_n,
   input  logic [DATA_W-1:0] wdata,
   output logic              wr_en,
   output logic              wr_val,
   output logic              rd_oe,
   output logic              bad_sel
);

   logic in_space;
   logic unused_hi;

   // flag space: strobe low while memory enable is high
   assign in_space  = ~sem_n & ce_n;
   assign bad_sel   = ~sem_n & ~ce_n;
   assign wr_en     = in_space & ~rw;
   assign wr_val    = wdata[0];
   assign rd_oe     = in_space & rw & ~oe_n;
   assign unused_hi = ^wdata[DATA_W-1:1];

endmodule

// File: rtl/xsema_cell.sv
module xsema_cell
   import xsema_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic l_wr,
   input  logic l_val,
   input  logic r_wr,
   input  logic r_val,
   output logic l_view,
   output logic r_view
);

   own_e own_q, own_d;
   logic lp_q, lp_d;
   logic rp_q, rp_d;
   logic l_req, l_rel, r_req, r_rel;

   assign l_req = l_wr & ~l_val;
   assign l_rel = l_wr &  l_val;
   assign r_req = r_wr & ~r_val;
   assign r_rel = r_wr &  r_val;

   always_comb begin
      own_d = own_q;
      lp_d  = lp_q;
      rp_d  = rp_q;
      if (l_rel) lp_d = 1'b0;
      if (r_rel) rp_d = 1'b0;
      case (own_q)
         OWN_FREE: begin
            if (rp_q && !r_rel) begin
               own_d = OWN_RIGHT;
               rp_d  = 1'b0;
               if (l_req) lp_d = 1'b1;
            end else if (lp_q && !l_rel) begin
               own_d = OWN_LEFT;
               lp_d  = 1'b0;
               if (r_req) rp_d = 1'b1;
            end else if (l_req) begin
               own_d = OWN_LEFT;
               if (r_req) rp_d = 1'b1;
            end else if (r_req) begin
               own_d = OWN_RIGHT;
            end
         end
         OWN_LEFT: begin
            if (l_rel) own_d = OWN_FREE;
            if (r_req) rp_d = 1'b1;
         end
         OWN_RIGHT: begin
            if (r_rel) own_d = OWN_FREE;
            if (l_req) lp_d = 1'b1;
         end
         default: own_d = OWN_FREE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_q <= OWN_FREE;
         lp_q  <= 1'b0;
         rp_q  <= 1'b0;
      end else begin
         own_q <= own_d;
         lp_q  <= lp_d;
         rp_q  <= rp_d;
      end
   end

   assign l_view = (own_q != OWN_LEFT);
   assign r_view = (own_q != OWN_RIGHT);

   // ownership never jumps straight from one port to the other
   assert_no_swap_l_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == OWN_LEFT) |=> (own_q != OWN_RIGHT));
   assert_no_swap_r_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == OWN_RIGHT) |=> (own_q != OWN_LEFT));
   // an owner never also has a pending claim on the same flag
   assert_pend_not_owner_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !((own_q == OWN_LEFT && lp_q) || (own_q == OWN_RIGHT && rp_q)));
   // tie on a free flag goes to the left port
   assert_tie_left_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == OWN_FREE && !lp_q && !rp_q && l_req && r_req)
      |=> (own_q == OWN_LEFT && rp_q));
   // release with a waiting claim: free for one cycle, then handed over
   assert_release_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == OWN_LEFT && l_rel && rp_q && !r_rel) |=> (own_q == OWN_FREE && rp_q));
   assert_pend_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == OWN_FREE && rp_q && !r_rel) |=> (own_q == OWN_RIGHT));

endmodule

// File: rtl/xsema_rd_mux.sv
module xsema_rd_mux #(
   parameter int NUM_FLAGS = 8,
   parameter int DATA_W    = 9,
   localparam int ADDR_W   = $clog2(NUM_FLAGS)
) (
   input  logic [NUM_FLAGS-1:0] view,
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 oe,
   output logic [DATA_W-1:0]    rdata
);

   logic bit_sel;

   assign bit_sel = view[addr];
   assign rdata   = oe ? {DATA_W{bit_sel}} : '0;

endmodule

// File: rtl/xsema_dual.sv
module xsema_dual #(
   parameter int NUM_FLAGS = 8,
   parameter int DATA_W    = 9,
   localparam int ADDR_W   = $clog2(NUM_FLAGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_ce_n,
   input  logic              l_sem_n,
   input  logic              l_rw,
   input  logic              l_oe_n,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   output logic [DATA_W-1:0] l_rdata,
   output logic              l_rdata_oe,
   output logic              l_bad_sel,
   input  logic              r_ce_n,
   input  logic              r_sem_n,
   input  logic              r_rw,
   input  logic              r_oe_n,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] r_rdata,
   output logic              r_rdata_oe,
   output logic              r_bad_sel
);

   if (NUM_FLAGS < 2 || (NUM_FLAGS & (NUM_FLAGS - 1)) != 0) begin : g_chk_flags
      $error("NUM_FLAGS must be a power of two, at least 2");
   end
   if (DATA_W < 2) begin : g_chk_data
      $error("DATA_W must be at least 2");
   end

   logic l_wr_en, l_wr_val, r_wr_en, r_wr_val;
   logic [NUM_FLAGS-1:0] l_view, r_view;

   xsema_port_dec #(.DATA_W(DATA_W)) u_dec_l (
      .ce_n(l_ce_n), .sem_n(l_sem_n), .rw(l_rw), .oe_n(l_oe_n), .wdata(l_wdata),
      .wr_en(l_wr_en), .wr_val(l_wr_val), .rd_oe(l_rdata_oe), .bad_sel(l_bad_sel));

   xsema_port_dec #(.DATA_W(DATA_W)) u_dec_r (
      .ce_n(r_ce_n), .sem_n(r_sem_n), .rw(r_rw), .oe_n(r_oe_n), .wdata(r_wdata),
      .wr_en(r_wr_en), .wr_val(r_wr_val), .rd_oe(r_rdata_oe), .bad_sel(r_bad_sel));

   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
      logic l_hit, r_hit;
      assign l_hit = l_wr_en && (l_addr == ADDR_W'(i));
      assign r_hit = r_wr_en && (r_addr == ADDR_W'(i));
      xsema_cell u_cell (
         .clk(clk), .rst_n(rst_n),
         .l_wr(l_hit), .l_val(l_wr_val),
         .r_wr(r_hit), .r_val(r_wr_val),
         .l_view(l_view[i]), .r_view(r_view[i]));
   end

   xsema_rd_mux #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_mux_l (
      .view(l_view), .addr(l_addr), .oe(l_rdata_oe), .rdata(l_rdata));

   xsema_rd_mux #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_mux_r (
      .view(r_view), .addr(r_addr), .oe(r_rdata_oe), .rdata(r_rdata));

   // forbidden strobe pair never drives the read bus
   assert_bad_no_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (l_bad_sel || r_bad_sel) |-> !((l_bad_sel && l_rdata_oe) || (r_bad_sel && r_rdata_oe)));
   // read word is the flag replicated on every bit
   assert_read_repl_l_R5: assert property (@(posedge clk) disable iff (!rst_n)
      l_rdata_oe |-> (l_rdata == '0 || l_rdata == '1));
   assert_read_repl_r_R5: assert property (@(posedge clk) disable iff (!rst_n)
      r_rdata_oe |-> (r_rdata == '0 || r_rdata == '1));
   // the same flag is never seen as held by both ports
   assert_single_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (l_rdata_oe && r_rdata_oe && l_addr == r_addr) |-> !(l_rdata[0] == 1'b0 && r_rdata[0] == 1'b0));

endmodule

// File: tb/xsema_dual_tb_top.sv
module xsema_dual_tb_top;

   typedef struct packed {
      logic       ce_n;
      logic       sem_n;
      logic       rw;
      logic       oe_n;
      logic [2:0] addr;
      logic [8:0] wdata;
   } stim_t;

   typedef struct packed {
      logic       oe;
      logic [8:0] d;
      logic       bad;
   } px_t;

   typedef struct {
      px_t l;
      px_t r;
      int  req;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   stim_t ls, rs;
   logic [8:0] l_rdata, r_rdata;
   logic l_rdata_oe, r_rdata_oe, l_bad_sel, r_bad_sel;
   item_t q[$];
   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   xsema_dual dut_i (
      .clk(clk), .rst_n(rst_n),
      .l_ce_n(ls.ce_n), .l_sem_n(ls.sem_n), .l_rw(ls.rw), .l_oe_n(ls.oe_n),
      .l_addr(ls.addr), .l_wdata(ls.wdata),
      .l_rdata(l_rdata), .l_rdata_oe(l_rdata_oe), .l_bad_sel(l_bad_sel),
      .r_ce_n(rs.ce_n), .r_sem_n(rs.sem_n), .r_rw(rs.rw), .r_oe_n(rs.oe_n),
      .r_addr(rs.addr), .r_wdata(rs.wdata),
      .r_rdata(r_rdata), .r_rdata_oe(r_rdata_oe), .r_bad_sel(r_bad_sel));

   function automatic stim_t sw(input logic [2:0] a, input logic [8:0] d);
      return '{ce_n:1'b1, sem_n:1'b0, rw:1'b0, oe_n:1'b1, addr:a, wdata:d};
   endfunction
   function automatic stim_t sr(input logic [2:0] a);
      return '{ce_n:1'b1, sem_n:1'b0, rw:1'b1, oe_n:1'b0, addr:a, wdata:9'h0};
   endfunction
   function automatic stim_t si();
      return '{ce_n:1'b1, sem_n:1'b1, rw:1'b1, oe_n:1'b1, addr:3'd0, wdata:9'h0};
   endfunction
   function automatic px_t xr(input logic v);
      return '{oe:1'b1, d:{9{v}}, bad:1'b0};
   endfunction
   function automatic px_t xn();
      return '{oe:1'b0, d:9'h0, bad:1'b0};
   endfunction
   function automatic px_t xb();
      return '{oe:1'b0, d:9'h0, bad:1'b1};
   endfunction

   // driver: one cycle of stimulus and its expected port values
   task automatic step(input stim_t l, input stim_t r, input px_t el, input px_t er, input int req);
      item_t it;
      @(posedge clk);
      #1;
      ls = l;
      rs = r;
      it.l = el;
      it.r = er;
      it.req = req;
      q.push_back(it);
   endtask

   // monitor: compares at the falling edge of the same cycle
   always @(negedge clk) begin
      if (q.size() > 0) begin
         item_t it;
         px_t gl, gr;
         it = q.pop_front();
         gl = '{oe:l_rdata_oe, d:l_rdata, bad:l_bad_sel};
         gr = '{oe:r_rdata_oe, d:r_rdata, bad:r_bad_sel};
         n_chk++;
         if (gl != it.l) begin
            n_fail++;
            $display("FAIL R%0d left got oe=%b d=%h bad=%b exp oe=%b d=%h bad=%b",
                     it.req, gl.oe, gl.d, gl.bad, it.l.oe, it.l.d, it.l.bad);
         end
         n_chk++;
         if (gr != it.r) begin
            n_fail++;
            $display("FAIL R%0d right got oe=%b d=%h bad=%b exp oe=%b d=%h bad=%b",
                     it.req, gr.oe, gr.d, gr.bad, it.r.oe, it.r.d, it.r.bad);
         end
      end
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 20000 && !done) begin
         n_fail++;
         $display("FAIL watchdog expired got cycle %0d exp finish", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      ls = si();
      rs = si();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: every flag free after reset
      for (int a = 0; a < 8; a++) step(sr(3'(a)), sr(3'(a)), xr(1'b1), xr(1'b1), 1);

      // R6: left claims flag 2
      step(sw(3'd2, 9'h000), si(), xn(), xn(), 6);
      step(sr(3'd2), sr(3'd2), xr(1'b0), xr(1'b1), 6);

      // R4: right claims flag 5 with only bit 0 low, then R10 releases with 9'h001
      step(si(), sw(3'd5, 9'h1FE), xn(), xn(), 4);
      step(sr(3'd5), sr(3'd5), xr(1'b1), xr(1'b0), 4);
      step(si(), sw(3'd5, 9'h001), xn(), xn(), 10);
      step(sr(3'd5), sr(3'd5), xr(1'b1), xr(1'b1), 10);

      // R7: right claims flag 2 held by left
      step(si(), sw(3'd2, 9'h000), xn(), xn(), 7);
      step(sr(3'd2), sr(3'd2), xr(1'b0), xr(1'b1), 7);
      // R9: left releases, free one cycle, then right owns
      step(sw(3'd2, 9'h001), si(), xn(), xn(), 9);
      step(sr(3'd2), sr(3'd2), xr(1'b1), xr(1'b1), 9);
      step(sr(3'd2), sr(3'd2), xr(1'b1), xr(1'b0), 9);

      // R10: left queues on flag 2 then withdraws; right still owns
      step(sw(3'd2, 9'h000), si(), xn(), xn(), 10);
      step(sw(3'd2, 9'h1FF), si(), xn(), xn(), 10);
      step(sr(3'd2), sr(3'd2), xr(1'b1), xr(1'b0), 10);
      step(si(), sw(3'd2, 9'h001), xn(), xn(), 10);
      step(sr(3'd2), sr(3'd2), xr(1'b1), xr(1'b1), 10);
      step(sr(3'd2), sr(3'd2), xr(1'b1), xr(1'b1), 10);

      // R8: tie on flag 6, left wins, right gets it after release
      step(sw(3'd6, 9'h000), sw(3'd6, 9'h000), xn(), xn(), 8);
      step(sr(3'd6), sr(3'd6), xr(1'b0), xr(1'b1), 8);
      step(sw(3'd6, 9'h001), si(), xn(), xn(), 8);
      step(sr(3'd6), sr(3'd6), xr(1'b1), xr(1'b1), 9);
      step(sr(3'd6), sr(3'd6), xr(1'b1), xr(1'b0), 8);
      step(si(), sw(3'd6, 9'h001), xn(), xn(), 8);

      // R2: memory-selected and deselected writes leave flag 7 free
      step('{ce_n:1'b0, sem_n:1'b1, rw:1'b0, oe_n:1'b1, addr:3'd7, wdata:9'h0},
           '{ce_n:1'b1, sem_n:1'b1, rw:1'b0, oe_n:1'b1, addr:3'd7, wdata:9'h0}, xn(), xn(), 2);
      step(sr(3'd7), sr(3'd7), xr(1'b1), xr(1'b1), 2);
      step('{ce_n:1'b0, sem_n:1'b1, rw:1'b1, oe_n:1'b0, addr:3'd7, wdata:9'h0},
           '{ce_n:1'b1, sem_n:1'b1, rw:1'b1, oe_n:1'b0, addr:3'd7, wdata:9'h0}, xn(), xn(), 2);

      // R3: forbidden strobe pair flags misuse and does nothing
      step('{ce_n:1'b0, sem_n:1'b0, rw:1'b0, oe_n:1'b1, addr:3'd4, wdata:9'h0}, si(), xb(), xn(), 3);
      step(sr(3'd4), sr(3'd4), xr(1'b1), xr(1'b1), 3);
      step(si(), '{ce_n:1'b0, sem_n:1'b0, rw:1'b1, oe_n:1'b0, addr:3'd4, wdata:9'h0}, xn(), xb(), 3);

      // R5: read with output enable high keeps the bus off
      step('{ce_n:1'b1, sem_n:1'b0, rw:1'b1, oe_n:1'b1, addr:3'd5, wdata:9'h0},
           '{ce_n:1'b1, sem_n:1'b0, rw:1'b1, oe_n:1'b1, addr:3'd5, wdata:9'h0}, xn(), xn(), 5);

      // R11: different flags claimed at once stay independent
      step(sw(3'd0, 9'h000), sw(3'd1, 9'h000), xn(), xn(), 11);
      step(sr(3'd0), sr(3'd1), xr(1'b0), xr(1'b0), 11);
      step(sr(3'd1), sr(3'd0), xr(1'b1), xr(1'b1), 11);

      step(si(), si(), xn(), xn(), 2);
      @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule